// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Port

This block is the host-facing register access unit of a network controller. A CPU reaches it either over a separate address bus or over a multiplexed bus. On the multiplexed bus the low data lines first carry the register address, which a latch enable captures. The port accepts two strobe styles. One uses separate active-low read and write strobes. The other uses a direction input with an active-low data strobe. Mode pins select the bus form and the strobe style, and every input is sampled on the core clock.

Eight register addresses are decoded. The block itself holds a status/interrupt-mask pair and a configuration register, and it passes a data register through to the controller core. Data-register transfers may be 16 bits wide through an upper byte lane. A swapper can exchange the two bytes. A push-pull active-low indicator marks wide data-register accesses. A DMA request with selectable polarity lets the core ask for transfers, and the matching active-low acknowledge steers bus cycles to the data register. A timing-select pin lets writes commit on the leading strobe edge, but only on a non-multiplexed bus.

Top module: `hbi_host_port`

## Requirements
- R1: With `mux_n` low, the register address is taken from `d_lo_in[2:0]` and tracks it while `ale` is high. After `ale` falls the address holds the last value sampled with `ale` high, and `addr_in` is ignored. With `mux_n` high, `addr_in` is used directly.
- R2: With `moto` low, a low `rd_ds` (with `wr_dir` high) is a read, and a low `wr_dir` (with `rd_ds` high) is a write.
- R3: With `moto` high, `rd_ds` is an active-low data strobe, and `wr_dir` gives the direction: high for a read, low for a write.
- R4: Address 0 reads `st_in` and a write to it sets the interrupt mask. Address 1 is the configuration register: bit0 enables 16-bit data, bit1 swaps bytes, bit2 sets DMA request polarity (0 = active high) and bit3 enables DMA; its upper bits read 0. Address 2 is the data register. Addresses 3 to 7 read 0 and ignore writes. Reset clears configuration and mask.
- R5: In normal timing, a write commits in the first cycle sampled with the strobe inactive, using the data of the last active cycle. `dat_wr` pulses for one cycle after that. When `tmg_n` is low and `mux_n` is high, the write instead commits in the first active cycle.
- R6: `d_lo_oe` is high exactly during a selected read. `d_hi_oe` is high only for a data-register read with 16-bit enabled.
- R7: `wide_n` is low exactly when the data register is selected (`cs_n` low at address 2, or `dack_n` low) and 16-bit is enabled.
- R8: On a 16-bit data access with swap clear, the low lane is word bits 7:0. With swap set the lanes are exchanged, for both reads and writes. On an 8-bit access the low lane is bits 7:0 and the written upper byte is 0.
- R9: The request level is DMA enable AND `dma_need` AND `dack_n` high. `dreq` equals that level XOR the polarity bit.
- R10: A low `dack_n` selects the data register regardless of `cs_n` and the address.
- R11: `irq_n` is low exactly when some bit is set in both `st_in` and the mask.
- R12: `dat_rd` pulses for one cycle, in the cycle after the first sampled cycle of a data-register read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| mux_n | input | 1 | Low selects the multiplexed bus |
| moto | input | 1 | High selects direction/data-strobe style |
| tmg_n | input | 1 | Low requests fast write timing |
| ale | input | 1 | Address latch enable (multiplexed bus) |
| addr_in | input | 3 | Separate address bus |
| cs_n | input | 1 | Active-low chip select |
| wr_dir | input | 1 | Write strobe or direction |
| rd_ds | input | 1 | Read strobe or data strobe |
| d_lo_in | input | 8 | Low data lane in (address on multiplexed bus) |
| d_lo_out | output | 8 | Low data lane out |
| d_lo_oe | output | 1 | Low lane drive enable |
| d_hi_in | input | 8 | High data lane in |
| d_hi_out | output | 8 | High data lane out |
| d_hi_oe | output | 1 | High lane drive enable |
| wide_n | output | 1 | Active-low 16-bit access indicator |
| dreq | output | 1 | DMA request, programmable polarity |
| dack_n | input | 1 | Active-low DMA acknowledge |
| irq_n | output | 1 | Active-low interrupt |
| st_in | input | 8 | Status bits from the core |
| dma_need | input | 1 | Core wants a DMA transfer |
| dat_rdata | input | 16 | Data register word from the core |
| dat_rd | output | 1 | Data register read pulse |
| dat_wr | output | 1 | Data register write pulse |
| dat_wdata | output | 16 | Data register word to the core |

## Verification
The interrupt output is fed by two things that can change in the same cycle: a committed mask write and a change on the status inputs. The bench makes a status bit rise in the very cycle where a trailing-edge mask write becomes effective. It then checks that `irq_n` stays high until the mask lands and goes low in the cycle after. In the same way, a DMA-acknowledged data write is issued while `dma_need` stays high. This checks that the request drops for the whole acknowledge and that the write still reaches the core.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
   localparam int RA_STAT = 0;
   localparam int RA_CFG  = 1;
   localparam int RA_DATA = 2;
   localparam int CFG_W   = 4;

   typedef struct packed {
      logic dma_en;
      logic pol;
      logic swap;
      logic wide;
   } cfg_t;
endpackage

// File: rtl/hbi_decode.sv
module hbi_decode #(
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mux_n,
   input  logic          moto,
   input  logic          ale,
   input  logic [AW-1:0] addr_in,
   input  logic [AW-1:0] lo_addr,
   input  logic          cs_n,
   input  logic          wr_dir,
   input  logic          rd_ds,
   input  logic          dack_n,
   output logic [AW-1:0] addr,
   output logic          sel,
   output logic          rd_act,
   output logic          wr_act
);
   import hbi_pkg::*;

   logic [AW-1:0] lat_q;
   logic [AW-1:0] bus_addr;
   logic          rd_raw, wr_raw, dma_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lat_q <= '0;
      else if (ale) lat_q <= lo_addr;
   end

   always_comb begin
      if (mux_n)    bus_addr = addr_in;
      else if (ale) bus_addr = lo_addr;
      else          bus_addr = lat_q;
   end

   assign dma_sel = ~dack_n;
   assign sel     = ~cs_n | dma_sel;
   assign addr    = dma_sel ? AW'(RA_DATA) : bus_addr;

   // read decode is the same in both styles; write differs
   assign rd_raw = ~rd_ds & wr_dir;
   assign wr_raw = moto ? (~rd_ds & ~wr_dir) : (~wr_dir & rd_ds);

   assign rd_act = sel & rd_raw;
   assign wr_act = sel & wr_raw;

   // R1
   lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mux_n && !ale && !dack_n == 1'b0) |=> (!ale || !mux_n == 1'b0) || ($past(lat_q) == lat_q));
endmodule

// File: rtl/hbi_swap.sv
module hbi_swap #(
   parameter int DW     = 8,
   parameter bit HAS_HI = 1'b1
) (
   input  logic          wide,
   input  logic          swap,
   input  logic [DW-1:0] lo_in,
   input  logic [DW-1:0] hi_in,
   input  logic [2*DW-1:0] rword,
   output logic [DW-1:0] lo_out,
   output logic [DW-1:0] hi_out,
   output logic [2*DW-1:0] wword
);
   generate
      if (HAS_HI) begin : g_wide
         logic xch;
         assign xch    = wide & swap;
         assign lo_out = xch ? rword[2*DW-1:DW] : rword[DW-1:0];
         assign hi_out = xch ? rword[DW-1:0]    : rword[2*DW-1:DW];
         always_comb begin
            if (!wide)     wword = {{DW{1'b0}}, lo_in};
            else if (swap) wword = {lo_in, hi_in};
            else           wword = {hi_in, lo_in};
         end
      end else begin : g_narrow
         logic unused_ok;
         assign unused_ok = ^{wide, swap, hi_in, rword[2*DW-1:DW]};
         assign lo_out    = rword[DW-1:0];
         assign hi_out    = '0;
         assign wword     = {{DW{1'b0}}, lo_in};
      end
   endgenerate
endmodule

// File: rtl/hbi_regs.sv
module hbi_regs #(
   parameter int DW     = 8,
   parameter int AW     = 3,
   parameter bit HAS_HI = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fast_ok,
   input  logic [AW-1:0]   addr,
   input  logic            wr_act,
   input  logic            rd_act,
   input  logic [2*DW-1:0] wword,
   input  logic [DW-1:0]   lo_in,
   output hbi_pkg::cfg_t   cfg,
   output logic [DW-1:0]   mask,
   output logic            dat_wr,
   output logic [2*DW-1:0] dat_wdata,
   output logic            dat_rd
);
   import hbi_pkg::*;

   logic            wr_q, rd_q, commit;
   logic [AW-1:0]   addr_q, c_addr;
   logic [2*DW-1:0] ww_q, c_ww;
   logic [DW-1:0]   lo_q, c_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q   <= 1'b0;
         rd_q   <= 1'b0;
         addr_q <= '0;
         ww_q   <= '0;
         lo_q   <= '0;
      end else begin
         wr_q <= wr_act;
         rd_q <= rd_act;
         if (wr_act) begin
            addr_q <= addr;
            ww_q   <= wword;
            lo_q   <= lo_in;
         end
      end
   end

   // leading-edge commit in fast timing, trailing-edge otherwise
   assign commit = fast_ok ? (wr_act & ~wr_q) : (~wr_act & wr_q);
   assign c_addr = fast_ok ? addr  : addr_q;
   assign c_ww   = fast_ok ? wword : ww_q;
   assign c_lo   = fast_ok ? lo_in : lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg       <= '0;
         mask      <= '0;
         dat_wr    <= 1'b0;
         dat_wdata <= '0;
         dat_rd    <= 1'b0;
      end else begin
         dat_wr <= commit && (c_addr == AW'(RA_DATA));
         dat_rd <= rd_act && !rd_q && (addr == AW'(RA_DATA));
         if (commit && (c_addr == AW'(RA_DATA))) dat_wdata <= c_ww;
         if (commit && (c_addr == AW'(RA_STAT))) mask <= c_lo;
         if (commit && (c_addr == AW'(RA_CFG))) begin
            cfg      <= cfg_t'(c_lo[CFG_W-1:0]);
            cfg.wide <= HAS_HI & c_lo[0];
         end
      end
   end

   // R5
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr |=> !dat_wr);
   // R12
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_rd |=> !dat_rd);
   // R4
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_act && !wr_q |=> $stable(cfg));
endmodule

// File: rtl/hbi_host_port.sv
module hbi_host_port #(
   parameter int DW     = 8,
   parameter int AW     = 3,
   parameter bit HAS_HI = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mux_n,
   input  logic            moto,
   input  logic            tmg_n,
   input  logic            ale,
   input  logic [AW-1:0]   addr_in,
   input  logic            cs_n,
   input  logic            wr_dir,
   input  logic            rd_ds,
   input  logic [DW-1:0]   d_lo_in,
   output logic [DW-1:0]   d_lo_out,
   output logic            d_lo_oe,
   input  logic [DW-1:0]   d_hi_in,
   output logic [DW-1:0]   d_hi_out,
   output logic            d_hi_oe,
   output logic            wide_n,
   output logic            dreq,
   input  logic            dack_n,
   output logic            irq_n,
   input  logic [DW-1:0]   st_in,
   input  logic            dma_need,
   input  logic [2*DW-1:0] dat_rdata,
   output logic            dat_rd,
   output logic            dat_wr,
   output logic [2*DW-1:0] dat_wdata
);
   import hbi_pkg::*;

   localparam int WW = 2 * DW;

   generate
      if (AW < 2) begin : g_aw_bad
         $error("hbi_host_port: AW must reach the data register address");
      end
      if (DW < CFG_W) begin : g_dw_bad
         $error("hbi_host_port: DW narrower than the configuration field");
      end
   endgenerate

   logic [AW-1:0] addr;
   logic          sel, rd_act, wr_act, is_data, fast_ok;
   cfg_t          cfg;
   logic [DW-1:0] mask, sw_lo, sw_hi;
   logic [WW-1:0] wword;

   assign fast_ok = ~tmg_n & mux_n;

   hbi_decode #(.AW(AW)) u_dec (
      .clk(clk), .rst_n(rst_n), .mux_n(mux_n), .moto(moto), .ale(ale),
      .addr_in(addr_in), .lo_addr(d_lo_in[AW-1:0]), .cs_n(cs_n),
      .wr_dir(wr_dir), .rd_ds(rd_ds), .dack_n(dack_n),
      .addr(addr), .sel(sel), .rd_act(rd_act), .wr_act(wr_act)
   );

   hbi_swap #(.DW(DW), .HAS_HI(HAS_HI)) u_swap (
      .wide(cfg.wide), .swap(cfg.swap), .lo_in(d_lo_in), .hi_in(d_hi_in),
      .rword(dat_rdata), .lo_out(sw_lo), .hi_out(sw_hi), .wword(wword)
   );

   hbi_regs #(.DW(DW), .AW(AW), .HAS_HI(HAS_HI)) u_regs (
      .clk(clk), .rst_n(rst_n), .fast_ok(fast_ok), .addr(addr),
      .wr_act(wr_act), .rd_act(rd_act), .wword(wword), .lo_in(d_lo_in),
      .cfg(cfg), .mask(mask), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
      .dat_rd(dat_rd)
   );

   assign is_data = (addr == AW'(RA_DATA));

   always_comb begin
      unique case (1'b1)
         addr == AW'(RA_STAT): d_lo_out = st_in;
         addr == AW'(RA_CFG):  d_lo_out = {{(DW-CFG_W){1'b0}}, cfg};
         is_data:              d_lo_out = sw_lo;
         default:              d_lo_out = '0;
      endcase
   end

   assign d_lo_oe  = rd_act;
   assign d_hi_out = sw_hi;
   assign d_hi_oe  = rd_act & is_data & cfg.wide;
   assign wide_n   = ~(sel & is_data & cfg.wide);
   assign irq_n    = ~|(st_in & mask);
   assign dreq     = (cfg.dma_en & dma_need & dack_n) ^ cfg.pol;

   // R6
   hi_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_hi_oe |-> (d_lo_oe && !wide_n));
   // R9
   dack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dack_n |-> (dreq == cfg.pol));
   // R7
   wide_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_n |-> (sel && is_data));
   // R11
   irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_in == '0) |-> irq_n);
endmodule

// File: tb/hbi_host_port_tb.sv
module hbi_host_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mux_n = 1'b1, moto = 1'b0, tmg_n = 1'b1, ale = 1'b0;
   logic [2:0]  addr_in = '0;
   logic        cs_n = 1'b1, wr_dir = 1'b1, rd_ds = 1'b1, dack_n = 1'b1;
   logic [7:0]  d_lo_in = '0, d_hi_in = '0, st_in = '0;
   logic        dma_need = 1'b0;
   logic [15:0] dat_rdata = 16'hBEEF;
   logic [7:0]  d_lo_out, d_hi_out;
   logic        d_lo_oe, d_hi_oe, wide_n, dreq, irq_n, dat_rd, dat_wr;
   logic [15:0] dat_wdata;

   int nvec = 0, nerr = 0;
   bit done = 1'b0;

   // results captured by the bus tasks
   logic        w_early, w_late, w_wide_n, r_rdp, r_oe_after;
   logic [15:0] w_early_d, w_late_d;
   logic [7:0]  r_lo, r_hi;
   logic        r_lo_oe, r_hi_oe, r_wide_n;

   always #4 clk = ~clk;

   hbi_host_port dut_i (
      .clk(clk), .rst_n(rst_n), .mux_n(mux_n), .moto(moto), .tmg_n(tmg_n),
      .ale(ale), .addr_in(addr_in), .cs_n(cs_n), .wr_dir(wr_dir),
      .rd_ds(rd_ds), .d_lo_in(d_lo_in), .d_lo_out(d_lo_out),
      .d_lo_oe(d_lo_oe), .d_hi_in(d_hi_in), .d_hi_out(d_hi_out),
      .d_hi_oe(d_hi_oe), .wide_n(wide_n), .dreq(dreq), .dack_n(dack_n),
      .irq_n(irq_n), .st_in(st_in), .dma_need(dma_need),
      .dat_rdata(dat_rdata), .dat_rd(dat_rd), .dat_wr(dat_wr),
      .dat_wdata(dat_wdata)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic strobe(input bit is_rd);
      if (moto) begin rd_ds = 1'b0; wr_dir = is_rd; end
      else if (is_rd) begin rd_ds = 1'b0; wr_dir = 1'b1; end
      else begin wr_dir = 1'b0; rd_ds = 1'b1; end
   endtask

   task automatic idle();
      rd_ds = 1'b1; wr_dir = 1'b1; cs_n = 1'b1; dack_n = 1'b1;
   endtask

   task automatic addr_phase(input logic [2:0] a);
      @(negedge clk);
      if (!mux_n) begin
         ale = 1'b1; d_lo_in = {5'h1F, a};
         @(negedge clk);
         ale = 1'b0;
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] lo,
                         input logic [7:0] hi, input bit use_dack);
      addr_phase(a);
      if (use_dack) begin dack_n = 1'b0; addr_in = 3'd5; end
      else begin cs_n = 1'b0; addr_in = mux_n ? a : ~a; end
      d_lo_in = lo; d_hi_in = hi;
      strobe(1'b0);
      #1 w_wide_n = wide_n;
      @(negedge clk);
      w_early = dat_wr; w_early_d = dat_wdata;
      idle();
      @(negedge clk);
      w_late = dat_wr; w_late_d = dat_wdata;
   endtask

   task automatic bus_rd(input logic [2:0] a, input bit use_dack);
      addr_phase(a);
      if (use_dack) begin dack_n = 1'b0; addr_in = 3'd5; end
      else begin cs_n = 1'b0; addr_in = mux_n ? a : ~a; end
      strobe(1'b1);
      #1;
      r_lo = d_lo_out; r_hi = d_hi_out;
      r_lo_oe = d_lo_oe; r_hi_oe = d_hi_oe; r_wide_n = wide_n;
      @(negedge clk);
      r_rdp = dat_rd;
      idle();
      #1 r_oe_after = d_lo_oe | d_hi_oe;
   endtask

   task automatic t_reset();
      st_in = 8'hFF; dma_need = 1'b1;
      #1;
      chk("R11 irq_n after reset", irq_n, 1);
      chk("R9 dreq after reset", dreq, 0);
      chk("R6 oe idle", {d_lo_oe, d_hi_oe}, 0);
      bus_rd(3'd1, 0);
      chk("R4 cfg reset value", r_lo, 8'h00);
      chk("R6 lo oe on read", r_lo_oe, 1);
      chk("R6 oe off after read", r_oe_after, 0);
      bus_rd(3'd6, 0);
      chk("R4 unused address reads 0", r_lo, 8'h00);
      st_in = 8'h00; dma_need = 1'b0;
   endtask

   task automatic t_wide_intel();
      bus_wr(3'd1, 8'h01, 8'h00, 0);
      bus_rd(3'd1, 0);
      chk("R4 cfg readback", r_lo, 8'h01);
      bus_wr(3'd2, 8'h34, 8'h12, 0);
      chk("R7 wide_n on 16-bit write", w_wide_n, 0);
      chk("R5 no early pulse in normal timing", w_early, 0);
      chk("R5 trailing pulse", w_late, 1);
      chk("R8 unswapped write word", w_late_d, 16'h1234);
      @(negedge clk);
      chk("R5 pulse is one cycle", dat_wr, 0);
      bus_rd(3'd2, 0);
      chk("R8 unswapped read lanes", {r_hi, r_lo}, 16'hBEEF);
      chk("R6 hi oe on wide read", r_hi_oe, 1);
      chk("R12 data read pulse", r_rdp, 1);
      @(negedge clk);
      chk("R12 read pulse one cycle", dat_rd, 0);
      bus_rd(3'd0, 0);
      chk("R7 wide_n high off data reg", r_wide_n, 1);
      chk("R6 hi oe off data reg", r_hi_oe, 0);
   endtask

   task automatic t_swap_narrow();
      bus_wr(3'd1, 8'h03, 8'h00, 0);
      bus_wr(3'd2, 8'h34, 8'h12, 0);
      chk("R8 swapped write word", w_late_d, 16'h3412);
      bus_rd(3'd2, 0);
      chk("R8 swapped read lanes", {r_hi, r_lo}, 16'hEFBE);
      bus_wr(3'd1, 8'h00, 8'h00, 0);
      bus_wr(3'd2, 8'h5A, 8'h77, 0);
      chk("R8 narrow write upper zero", w_late_d, 16'h005A);
      chk("R7 wide_n high when narrow", w_wide_n, 1);
      bus_rd(3'd2, 0);
      chk("R8 narrow read low lane", r_lo, 8'hEF);
      chk("R6 hi oe off when narrow", r_hi_oe, 0);
      bus_wr(3'd7, 8'hFF, 8'h00, 0);
      bus_rd(3'd1, 0);
      chk("R4 write to unused addr ignored", r_lo, 8'h00);
   endtask

   task automatic t_moto();
      moto = 1'b1;
      bus_wr(3'd1, 8'h01, 8'h00, 0);
      bus_rd(3'd1, 0);
      chk("R3 moto write/read cfg", r_lo, 8'h01);
      chk("R3 moto read drives lane", r_lo_oe, 1);
      bus_rd(3'd2, 0);
      chk("R3 moto data read pulse", r_rdp, 1);
      moto = 1'b0;
      bus_rd(3'd1, 0);
      chk("R2 intel read cfg", r_lo, 8'h01);
   endtask

   task automatic t_mux();
      mux_n = 1'b0;
      bus_wr(3'd1, 8'h03, 8'h00, 0);
      bus_rd(3'd1, 0);
      chk("R1 latched address write/read", r_lo, 8'h03);
      st_in = 8'hA5;
      bus_rd(3'd0, 0);
      chk("R1 latched address status", r_lo, 8'hA5);
      st_in = 8'h00;
      mux_n = 1'b1;
      bus_rd(3'd1, 0);
      chk("R1 direct address", r_lo, 8'h03);
   endtask

   task automatic t_fast();
      tmg_n = 1'b0;
      bus_wr(3'd1, 8'h01, 8'h00, 0);
      bus_wr(3'd2, 8'hCD, 8'hAB, 0);
      chk("R5 fast leading pulse", w_early, 1);
      chk("R5 fast data", w_early_d, 16'hABCD);
      chk("R5 fast no second pulse", w_late, 0);
      mux_n = 1'b0;
      bus_wr(3'd2, 8'h22, 8'h11, 0);
      chk("R5 fast ignored when muxed (early)", w_early, 0);
      chk("R5 fast ignored when muxed (late)", w_late, 1);
      mux_n = 1'b1; tmg_n = 1'b1;
   endtask

   task automatic t_irq_race();
      bus_wr(3'd0, 8'h04, 8'h00, 0);
      st_in = 8'h04; #1;
      chk("R11 masked bit asserts irq", irq_n, 0);
      st_in = 8'h02; #1;
      chk("R11 unmasked bit no irq", irq_n, 1);
      // status bit rises in the cycle the new mask commits
      @(negedge clk);
      cs_n = 1'b0; addr_in = 3'd0; d_lo_in = 8'h08; strobe(1'b0);
      @(negedge clk);
      idle(); st_in = 8'h08; #1;
      chk("R11 irq high before mask commits", irq_n, 1);
      @(negedge clk); #1;
      chk("R11 irq low after mask commits", irq_n, 0);
      st_in = 8'h00;
   endtask

   task automatic t_dma();
      bus_wr(3'd1, 8'h09, 8'h00, 0);
      dma_need = 1'b1; #1;
      chk("R9 dreq active high", dreq, 1);
      bus_wr(3'd0, 8'h00, 8'h00, 1);
      chk("R10 dack write goes to data reg", w_late, 1);
      chk("R10 dack write word", w_late_d, 16'h0000);
      chk("R7 wide_n on dack access", w_wide_n, 0);
      dack_n = 1'b0; #1;
      chk("R9 dreq drops under dack", dreq, 0);
      dack_n = 1'b1;
      bus_rd(3'd0, 1);
      chk("R10 dack read data lanes", {r_hi, r_lo}, 16'hBEEF);
      bus_wr(3'd1, 8'h0D, 8'h00, 0);
      #1;
      chk("R9 inverted polarity active", dreq, 0);
      dack_n = 1'b0; #1;
      chk("R9 inverted polarity idle", dreq, 1);
      dack_n = 1'b1; dma_need = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_wide_intel();
      t_swap_narrow();
      t_moto();
      t_mux();
      t_fast();
      t_irq_race();
      t_dma();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nvec++; nerr++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end
endmodule